// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block turns a 24-bit external bus address into four active-low chip-select pads. Each select has its own window, described by an enable, a base address kept at 4 KB granularity, and a power-of-two size code. An address that lands inside an enabled, correctly aligned window pulls that select's pad low. When windows overlap, a fixed ranking picks one winner. Addresses below a configurable internal-memory bound never reach the external bus.

A pad whose select is switched off is reused to carry one of the upper address lines A16 to A19. When the only enabled select is the last one, all four pads become address lines, which suits a memory that needs a wide row address and uses its own select. The block also produces the pad override controls. Data pads get both their value and their direction taken over while the bus is on. Address and control pads get only their value taken over.

Configuration arrives through a single write port that loads the complete setting of one select per write. The address is registered, and the pad values are registered on the same edge, so select and address lines change together.

Top module: `ebi_csdec`

## Requirements
- R1: A select with size code c covers 2^(8+c) bytes when c is 16 or less, and 16 MB when c is above 16. Its window starts at byte address base*4096, where base is the 12-bit base field. An address is inside the window when start <= addr < start + size.
- R2: While the bus is enabled, the pad of an enabled select whose window holds the address presented before a rising edge is driven low after that edge. Otherwise the pad is high.
- R3: When a window is larger than 4 KB and its start is not a multiple of its size, the cfg_err bit of that select (bit i for select i) reads 1 while the select is enabled, and its pad is never driven low.
- R4: When windows overlap, select 0 wins over 1, 1 over 2, and 2 over 3. At most one pad is driven low at a time.
- R5: Any address strictly below int_top keeps all four pads high, including pads that would otherwise select.
- R6: A pad whose select is disabled outputs address bit 16+i of the registered address (pad i carries A16+i) while the bus is enabled.
- R7: When the enable pattern is exactly select 3 alone, all four pads output A16 to A19 in the same pad order.
- R8: While bus_en is low, and during and after reset until the first decode, all pads are high.
- R9: addr_out is addr_in registered on each rising edge. The pads update on that same edge.
- R10: data_ovr_val and data_ovr_dir both equal bus_en. ac_ovr_val equals bus_en. ac_ovr_dir is always 0.
- R11: A write with cfg_we high loads cfg_en, cfg_base and cfg_code into select cfg_idx on the rising edge. The next decode uses the new setting, and the other selects are unchanged. Reset clears every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | External bus interface enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Select being written |
| cfg_en | input | 1 | Enable for the written select |
| cfg_base | input | 12 | Window start, address bits 23:12 |
| cfg_code | input | 5 | Size code, 2^(8+code) bytes, clipped at 16 MB |
| int_top | input | 24 | Internal-memory upper bound (exclusive) |
| addr_in | input | 24 | Bus address to decode |
| addr_out | output | 24 | Registered address lines |
| cs_pad_n | output | 4 | Select pads: active-low select or upper address line |
| cfg_err | output | 4 | Misaligned-window flag per select |
| data_ovr_val | output | 1 | Data pad value override |
| data_ovr_dir | output | 1 | Data pad direction override |
| ac_ovr_val | output | 1 | Address/control pad value override |
| ac_ovr_dir | output | 1 | Address/control pad direction override (always 0) |

## Verification
The bench probes the first and last byte of each window and the byte just past it. A decoder with an off-by-one size or a wrongly masked compare would select one byte too many or too few. It builds overlapping windows, so a reversed or missing priority shows up as the wrong pad going low or two pads low at once. It loads misaligned bases larger than 4 KB, which a design that skips the alignment test would let through as a select. It also covers the single-select-3 pattern, addresses at and just below the internal bound, and a disabled bus. These catch pads that keep selecting instead of carrying address bits, and an internal range that leaks through. Randomized configurations then mix all of these cases against a range-based reference model.

// File: rtl/ebi_cs_pkg.sv
package ebi_cs_pkg;
  parameter int AW      = 24;   // bus address width
  parameter int NCS     = 4;    // number of selects
  parameter int BASE_LSB = 12;  // base granularity (4 KB)
  parameter int SZW     = 5;    // size code width
  parameter int MIN_LG  = 8;    // smallest window, log2 bytes
  parameter int PIN_LSB = 16;   // first address bit carried on a select pad

  localparam int BW   = AW - BASE_LSB;
  localparam int IDXW = $clog2(NCS);

  typedef struct packed {
    logic          en;
    logic [BW-1:0] base;
    logic [SZW-1:0] code;
  } cs_cfg_t;

  // log2 of the window size, clipped to the full address space
  function automatic int unsigned win_lg(input logic [SZW-1:0] code);
    int unsigned lg;
    lg = MIN_LG + int'(code);
    if (lg > AW) lg = AW;
    return lg;
  endfunction

  // ones on the address bits that are compared against the base
  function automatic logic [AW-1:0] win_mask(input int unsigned lg);
    logic [AW-1:0] m;
    m = {AW{1'b1}};
    m = m << lg;
    return m;
  endfunction

  function automatic logic [AW-1:0] base_addr(input logic [BW-1:0] base);
    return {base, {BASE_LSB{1'b0}}};
  endfunction

  // base bits below the window size must be zero for windows above 4 KB
  function automatic logic base_misaligned(input logic [BW-1:0] base,
                                           input logic [SZW-1:0] code);
    int unsigned lg;
    lg = win_lg(code);
    if (lg <= BASE_LSB) return 1'b0;
    return |(base_addr(base) & ~win_mask(lg));
  endfunction

  function automatic logic win_hit(input logic [AW-1:0] addr,
                                   input logic [BW-1:0] base,
                                   input logic [SZW-1:0] code);
    return ((addr ^ base_addr(base)) & win_mask(win_lg(code))) == '0;
  endfunction
endpackage

// File: rtl/ebi_cs_cfg.sv
module ebi_cs_cfg
  import ebi_cs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDXW-1:0]     idx,
  input  cs_cfg_t             wdata,
  output cs_cfg_t [NCS-1:0]   cfg
);
  for (genvar g = 0; g < NCS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[g] <= '0;
      else if (we && (idx == IDXW'(g)))
        cfg[g] <= wdata;
    end
  end
endmodule

// File: rtl/ebi_cs_match.sv
module ebi_cs_match
  import ebi_cs_pkg::*;
(
  input  cs_cfg_t        cfg,
  input  logic [AW-1:0]  addr,
  output logic           hit,
  output logic           err
);
  always_comb begin
    err = cfg.en & base_misaligned(cfg.base, cfg.code);
    hit = cfg.en & ~err & win_hit(addr, cfg.base, cfg.code);
  end
endmodule

// File: rtl/ebi_cs_pick.sv
module ebi_cs_pick
  import ebi_cs_pkg::*;
(
  input  logic [NCS-1:0] hit,
  input  logic           block,
  output logic [NCS-1:0] grant
);
  // lowest index wins; internal region blocks everything
  always_comb begin
    logic taken;
    taken = block;
    grant = '0;
    for (int i = 0; i < NCS; i++) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebi_csdec.sv
module ebi_csdec
  import ebi_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic              cfg_en,
  input  logic [BW-1:0]     cfg_base,
  input  logic [SZW-1:0]    cfg_code,
  input  logic [AW-1:0]     int_top,
  input  logic [AW-1:0]     addr_in,
  output logic [AW-1:0]     addr_out,
  output logic [NCS-1:0]    cs_pad_n,
  output logic [NCS-1:0]    cfg_err,
  output logic              data_ovr_val,
  output logic              data_ovr_dir,
  output logic              ac_ovr_val,
  output logic              ac_ovr_dir
);
  cs_cfg_t [NCS-1:0] cfg;
  cs_cfg_t           wdata;
  logic [NCS-1:0]    hit;
  logic [NCS-1:0]    grant;
  logic [NCS-1:0]    en_vec;
  logic [NCS-1:0]    pin_is_addr;
  logic [NCS-1:0]    pad_d;
  logic              int_hit;
  logic              wide_mode;

  assign wdata = '{en: cfg_en, base: cfg_base, code: cfg_code};

  ebi_cs_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (wdata),
    .cfg   (cfg)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_match
    ebi_cs_match u_match (
      .cfg  (cfg[g]),
      .addr (addr_in),
      .hit  (hit[g]),
      .err  (cfg_err[g])
    );
    assign en_vec[g] = cfg[g].en;
  end

  assign int_hit = addr_in < int_top;

  ebi_cs_pick u_pick (
    .hit   (hit),
    .block (int_hit),
    .grant (grant)
  );

  // only the last select enabled: every pad becomes an address line
  assign wide_mode   = (en_vec == NCS'(1 << (NCS - 1)));
  assign pin_is_addr = wide_mode ? '1 : ~en_vec;

  always_comb begin
    for (int i = 0; i < NCS; i++) begin
      if (!bus_en)             pad_d[i] = 1'b1;
      else if (pin_is_addr[i]) pad_d[i] = addr_in[PIN_LSB + i];
      else                     pad_d[i] = ~grant[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
      cs_pad_n <= '1;
    end else begin
      addr_out <= addr_in;
      cs_pad_n <= pad_d;
    end
  end

  assign data_ovr_val = bus_en;
  assign data_ovr_dir = bus_en;
  assign ac_ovr_val   = bus_en;
  assign ac_ovr_dir   = 1'b0;
endmodule

// File: rtl/ebi_cs_chk.sv
module ebi_cs_chk
  import ebi_cs_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           bus_en,
  input logic [AW-1:0]  addr_in,
  input logic [AW-1:0]  addr_out,
  input logic [NCS-1:0] cs_pad_n,
  input logic [NCS-1:0] grant,
  input logic [NCS-1:0] cfg_err,
  input logic           int_hit
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4

  AST_INT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |-> (grant == '0)); // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & cfg_err) == '0); // R3

  AST_BUS_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> (cs_pad_n == '1)); // R8

  AST_ADDR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (addr_out == $past(addr_in))); // R9
endmodule

bind ebi_csdec ebi_cs_chk u_chk (.*);

// File: tb/sim_ebi_csdec.sv
module sim_ebi_csdec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [11:0] cfg_base = '0;
  logic [4:0]  cfg_code = '0;
  logic [23:0] int_top = '0;
  logic [23:0] addr_in = '0;
  logic [23:0] addr_out;
  logic [3:0]  cs_pad_n;
  logic [3:0]  cfg_err;
  logic        data_ovr_val, data_ovr_dir, ac_ovr_val, ac_ovr_dir;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference configuration
  bit          m_en   [4];
  int unsigned m_base [4];
  int unsigned m_code [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ebi_csdec u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_code(cfg_code), .int_top(int_top), .addr_in(addr_in),
    .addr_out(addr_out), .cs_pad_n(cs_pad_n), .cfg_err(cfg_err),
    .data_ovr_val(data_ovr_val), .data_ovr_dir(data_ovr_dir),
    .ac_ovr_val(ac_ovr_val), .ac_ovr_dir(ac_ovr_dir)
  );

  function automatic longint win_size(int unsigned code);
    if (code > 16) return 64'd1 << 24;
    return 64'd1 << (8 + code);
  endfunction

  function automatic bit bad_align(int i);
    longint start = longint'(m_base[i]) * 4096;
    longint sz = win_size(m_code[i]);
    return (sz > 4096) && ((start % sz) != 0);
  endfunction

  function automatic bit in_win(int i, longint a);
    longint start = longint'(m_base[i]) * 4096;
    return (a >= start) && (a < start + win_size(m_code[i]));
  endfunction

  function automatic logic [3:0] exp_err();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = m_en[i] && bad_align(i);
    return e;
  endfunction

  function automatic logic [3:0] exp_pads(logic [23:0] a, logic [23:0] top, logic ben);
    logic [3:0] p;
    bit only3, won;
    only3 = m_en[3] && !m_en[0] && !m_en[1] && !m_en[2];
    won = (a < top);
    p = 4'hF;
    if (!ben) return p;
    for (int i = 0; i < 4; i++) begin
      if (only3 || !m_en[i]) p[i] = a[16 + i];
      else if (!won && !bad_align(i) && in_win(i, longint'(a))) begin
        p[i] = 1'b0;
        won = 1;
      end
    end
    return p;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int idx, bit en, int unsigned base, int unsigned code);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_en = en;
    cfg_base = 12'(base); cfg_code = 5'(code);
    @(posedge clk);
    m_en[idx] = en; m_base[idx] = base & 12'hFFF; m_code[idx] = code & 5'h1F;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic step(string tag, logic [23:0] a);
    @(negedge clk);
    addr_in = a;
    @(posedge clk);
    #1;
    check(tag, {28'd0, cs_pad_n}, {28'd0, exp_pads(a, int_top, bus_en)});
    check("R9 addr_out", {8'd0, addr_out}, {8'd0, a});
    check("R3 cfg_err", {28'd0, cfg_err}, {28'd0, exp_err()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_base[i] = 0; m_code[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 reset pads", {28'd0, cs_pad_n}, 32'hF);
    check("R9 reset addr", {8'd0, addr_out}, 32'h0);
    check("R11 reset cfg_err", {28'd0, cfg_err}, 32'h0);
    @(negedge clk);
    rst_n = 1;

    // R10 override outputs with bus off
    #1;
    check("R10 data val off", {31'd0, data_ovr_val}, 0);
    check("R10 ac dir off", {31'd0, ac_ovr_dir}, 0);
    step("R8 bus off, no config", 24'h123456);
    bus_en = 1;
    #1;
    check("R10 data val", {31'd0, data_ovr_val}, 1);
    check("R10 data dir", {31'd0, data_ovr_dir}, 1);
    check("R10 ac val", {31'd0, ac_ovr_val}, 1);
    check("R10 ac dir", {31'd0, ac_ovr_dir}, 0);

    // R6 all disabled: pads carry A16..A19
    step("R6 all pads address", 24'hA5_0000);
    step("R6 all pads address", 24'h5A_FFFF);

    // R1/R2 64 KB window at 0x010000 on select 0
    wr(0, 1, 12'h010, 8);
    step("R2 first byte", 24'h010000);
    step("R1 last byte", 24'h01FFFF);
    step("R1 one past end", 24'h020000);
    step("R1 one before start", 24'h00FFFF);

    // R1 sub-4KB window: 256 B at 0x003000 on select 2
    wr(2, 1, 12'h003, 0);
    step("R1 256B last", 24'h0030FF);
    step("R1 256B past", 24'h003100);

    // R4 overlap: 1 MB at 0 on select 1 covers select 0's window
    wr(1, 1, 12'h000, 12);
    step("R4 sel0 wins", 24'h018000);
    step("R4 sel1 alone", 24'h040000);
    step("R4 sel1 over sel2", 24'h003010);

    // R5 internal range
    int_top = 24'h018001;
    step("R5 below bound", 24'h018000);
    step("R5 at bound", 24'h018001);
    int_top = 0;

    // R3 misaligned 64 KB window
    wr(3, 1, 12'h011, 8);
    step("R3 misaligned quiet", 24'h011000);
    wr(3, 1, 12'h800, 16);
    step("R3 misaligned 16MB", 24'h900000);
    wr(3, 1, 12'h800, 15);
    step("R3 aligned 8MB sel3", 24'h900000);

    // R7 only select 3 enabled
    wr(0, 0, 0, 0); wr(1, 0, 0, 0); wr(2, 0, 0, 0);
    step("R7 wide address mode", 24'h950000);
    step("R7 wide address mode", 24'hA30000);

    // R11 write touches one slot only
    wr(1, 1, 12'h900, 8);
    step("R11 new slot used", 24'h905555);
    step("R11 slot3 unchanged", 24'hA00000);

    // R8 bus disabled
    bus_en = 0;
    step("R8 bus off", 24'h905555);
    bus_en = 1;

    // random configurations
    for (int c = 0; c < 60; c++) begin
      for (int i = 0; i < 4; i++) begin
        int unsigned code = $urandom % 18;
        int unsigned base = $urandom % 4096;
        longint sz = win_size(code);
        if (($urandom % 4) != 0 && sz > 4096) base = base & ~(int'(sz / 4096) - 1);
        wr(i, ($urandom % 4) != 0, base, code);
      end
      int_top = ($urandom % 3 == 0) ? 24'($urandom % 24'h200000) : 24'h0;
      bus_en = ($urandom % 8) != 0;
      for (int k = 0; k < 12; k++) begin
        logic [23:0] a;
        int j = $urandom % 4;
        if ($urandom % 4 == 0) a = 24'($urandom);
        else a = 24'(longint'(m_base[j]) * 4096 + ($urandom % (2 * win_size(m_code[j]))) - 4);
        step("R2/R4/R5/R6/R7 random", a);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule